// File: doc/BRIEF.md
# Clock-generator status flag register

This block holds the status and event flags of a clock and reset generator and presents them as one 8-bit read image on a simple register bus. It tracks four sources. The first is a power-on event. The second is an illegal-address access pulse. The third is the lock indication of a frequency-locked loop. The fourth is the startup-complete indication of the oscillator. The loop, the oscillator and the startup timer are outside the block.

The lock and startup indications arrive asynchronously. Each passes through a two-flop synchronizer before it is used. The event flags are sticky, and software clears them by writing 1 to the matching bit. A change in lock status raises a lock-change flag. That flag drives an interrupt request when the lock interrupt enable is high. Two actions drop the lock status to 0 without raising the lock-change flag: entering stop mode and writing one of the loop's configuration registers. The oscillator monitor enable output is high only while the oscillator-up bit is 1.

Top module: `clkgen_status_reg`

## Requirements
- R1: While `por_n` is low and on the first cycle after it rises, `bus_rdata` reads 0x40, and `irq` and `osc_mon_en` are 0.
- R2: The power-on flag is at bit 6. A bus write with bit 6 = 1 clears it. A write with bit 6 = 0 leaves it unchanged, and so does `sys_rst`. Only `por_n` low sets it.
- R3: The illegal-address flag is at bit 2. It is set at the clock edge where `ill_acc` is 1 and cleared by a bus write with bit 2 = 1. `por_n` low clears it. `sys_rst` leaves it unchanged.
- R4: The lock status bit is at bit 3. It takes the value of `fll_lock_raw` on the third rising edge after that input changes (two synchronizer flops, then the status flop). Bus writes to bit 3 have no effect.
- R5: The lock-change flag is at bit 4. It is set at the same edge where the lock status changes by following the loop, whether it rises or falls. Only a bus write with bit 4 = 1 clears it, apart from the resets.
- R6: An edge where `stop_enter` is 1, or any bit of `cfg_wr` is 1, forces the lock status to 0. The lock-change flag is not set at that edge.
- R7: The oscillator-up bit is at bit 1. It becomes 1 on the third rising edge after `osc_ready_raw` goes high, provided `osc_en` is 1. It then holds, even if `osc_ready_raw` falls. It goes to 0 at the next edge where `osc_en` is 0 or `stop_enter` is 1. Bus writes to it have no effect.
- R8: `osc_mon_en` equals the oscillator-up bit at all times.
- R9: `irq` is 1 exactly when the lock-change flag is 1 and `lock_irq_en` is 1.
- R10: When a set event and a write-1 clear hit the same flag at one edge, the flag ends up 1.
- R11: Bits 7, 5 and 0 of `bus_rdata` always read 0. `bus_rdata` shows the current image whatever the value of `bus_sel`.
- R12: `sys_rst` at an edge clears the lock status, the lock-change flag, the oscillator-up bit and both synchronizers. It leaves the power-on and illegal-address flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst | input | 1 | System reset, synchronous, active high |
| ill_acc | input | 1 | Illegal-address access pulse |
| fll_lock_raw | input | 1 | Raw lock indication from the loop (asynchronous) |
| osc_ready_raw | input | 1 | Oscillator startup-done indication (asynchronous) |
| osc_en | input | 1 | Oscillator enable |
| stop_enter | input | 1 | Stop-mode entry pulse |
| cfg_wr | input | NUM_CFG | Write strobes of the loop's control, multiplier, trim-high and trim-low registers |
| lock_irq_en | input | 1 | Lock interrupt enable |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_wdata | input | 8 | Write data, a 1 clears the matching flag |
| bus_rdata | output | 8 | Status image |
| irq | output | 1 | Lock-change interrupt request |
| osc_mon_en | output | 1 | Oscillator monitor enable |

## Verification
Two functions can land on the same edge in this block. The first pair is a set event and a write-1 clear of the same flag. The second pair is a lock-status change and a lock kill.

The bench provokes each pair directly:
- An illegal-access pulse is issued together with a write of 0x04.
- A configuration write or a stop entry is issued while the synchronized lock is high.

In the random phase, bus writes, kills and lock toggles also coincide freely. The result is judged at the ports. The flag must read 1 after a set and a clear that coincide. After a kill, the lock status must read 0 with the lock-change flag still 0. The lock status then comes back one edge later with the flag raised.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_POR   = 6;
  localparam int BIT_LCHG  = 4;
  localparam int BIT_LOCK  = 3;
  localparam int BIT_ILL   = 2;
  localparam int BIT_OSCUP = 1;

  function automatic logic [REG_W-1:0] pack_status(logic por, logic chg, logic lock,
                                                   logic ill, logic up);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_POR]   = por;
    v[BIT_LCHG]  = chg;
    v[BIT_LOCK]  = lock;
    v[BIT_ILL]   = ill;
    v[BIT_OSCUP] = up;
    return v;
  endfunction

  function automatic logic w1c_hit(logic strobe, logic [REG_W-1:0] wdata, int pos);
    return strobe & wdata[pos];
  endfunction
endpackage

// File: rtl/cgs_sync.sv
module cgs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         sys_rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES < 2) begin : g_single
      logic [W-1:0] stage;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       stage <= '0;
        else if (sys_rst) stage <= '0;
        else              stage <= d;
      end
      assign q = stage;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       chain <= '0;
        else if (sys_rst) chain <= '0;
        else              chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cgs_sticky.sv
module cgs_sticky #(
  parameter logic RESET_VAL = 1'b0,
  parameter logic SYS_CLEAR = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst,
  input  logic set_evt,
  input  logic clr_evt,
  output logic q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                    q <= RESET_VAL;
    else if (SYS_CLEAR && sys_rst) q <= 1'b0;
    else if (set_evt)              q <= 1'b1;
    else if (clr_evt)              q <= 1'b0;
  end
endmodule

// File: rtl/cgs_lock_track.sv
module cgs_lock_track (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst,
  input  logic lock_in,
  input  logic kill,
  output logic lock_st,
  output logic chg_evt
);
  assign chg_evt = !kill && !sys_rst && (lock_in != lock_st);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               lock_st <= 1'b0;
    else if (sys_rst || kill) lock_st <= 1'b0;
    else                      lock_st <= lock_in;
  end
endmodule

// File: rtl/cgs_osc_track.sv
module cgs_osc_track (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst,
  input  logic osc_en,
  input  logic stop_enter,
  input  logic ready_in,
  output logic osc_up,
  output logic drop_evt
);
  assign drop_evt = !osc_en || stop_enter;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        osc_up <= 1'b0;
    else if (sys_rst)  osc_up <= 1'b0;
    else if (drop_evt) osc_up <= 1'b0;
    else if (ready_in) osc_up <= 1'b1;
  end
endmodule

// File: rtl/clkgen_status_reg.sv
module clkgen_status_reg
  import cgs_pkg::*;
#(
  parameter int NUM_CFG     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               sys_rst,
  input  logic               ill_acc,
  input  logic               fll_lock_raw,
  input  logic               osc_ready_raw,
  input  logic               osc_en,
  input  logic               stop_enter,
  input  logic [NUM_CFG-1:0] cfg_wr,
  input  logic               lock_irq_en,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               irq,
  output logic               osc_mon_en
);
  logic [1:0] raw_in, synced;
  logic lock_sync, ready_sync;
  logic bus_wr_evt, kill_evt, chg_evt, drop_evt;
  logic clr_por, clr_ill, clr_chg;
  logic por_flag, ill_flag, chg_flag, lock_st, osc_up;
  logic unused_wbits;

  assign raw_in = {osc_ready_raw, fll_lock_raw};

  cgs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .d(raw_in), .q(synced)
  );
  assign lock_sync  = synced[0];
  assign ready_sync = synced[1];

  assign bus_wr_evt = bus_sel & bus_wr;
  assign kill_evt   = stop_enter | (|cfg_wr);
  assign clr_por    = w1c_hit(bus_wr_evt, bus_wdata, BIT_POR);
  assign clr_ill    = w1c_hit(bus_wr_evt, bus_wdata, BIT_ILL);
  assign clr_chg    = w1c_hit(bus_wr_evt, bus_wdata, BIT_LCHG);
  assign unused_wbits = ^{bus_wdata[7], bus_wdata[5], bus_wdata[3], bus_wdata[1:0]};

  cgs_lock_track u_lock (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .lock_in(lock_sync),
    .kill(kill_evt), .lock_st(lock_st), .chg_evt(chg_evt)
  );

  cgs_osc_track u_osc (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .osc_en(osc_en),
    .stop_enter(stop_enter), .ready_in(ready_sync), .osc_up(osc_up),
    .drop_evt(drop_evt)
  );

  cgs_sticky #(.RESET_VAL(1'b1), .SYS_CLEAR(1'b0)) u_por_flag (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .set_evt(1'b0),
    .clr_evt(clr_por), .q(por_flag)
  );

  cgs_sticky #(.RESET_VAL(1'b0), .SYS_CLEAR(1'b0)) u_ill_flag (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .set_evt(ill_acc),
    .clr_evt(clr_ill), .q(ill_flag)
  );

  cgs_sticky #(.RESET_VAL(1'b0), .SYS_CLEAR(1'b1)) u_chg_flag (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .set_evt(chg_evt),
    .clr_evt(clr_chg), .q(chg_flag)
  );

  assign bus_rdata  = pack_status(por_flag, chg_flag, lock_st, ill_flag, osc_up);
  assign irq        = chg_flag & lock_irq_en;
  assign osc_mon_en = osc_up;
endmodule

// File: rtl/cgs_status_checker.sv
module cgs_status_checker
  import cgs_pkg::*;
(
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst,
  input logic             bus_wr_evt,
  input logic [REG_W-1:0] bus_wdata,
  input logic             ill_acc,
  input logic             kill_evt,
  input logic             osc_en,
  input logic             stop_enter,
  input logic             lock_irq_en,
  input logic [REG_W-1:0] bus_rdata,
  input logic             irq,
  input logic             osc_mon_en
);
  p_por_sticky_r2: assert property (@(posedge clk) disable iff (!por_n)
    !(bus_wr_evt && bus_wdata[BIT_POR]) |=> $stable(bus_rdata[BIT_POR]));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!por_n)
    ill_acc |=> bus_rdata[BIT_ILL]);

  p_kill_quiet_r6: assert property (@(posedge clk) disable iff (!por_n)
    (kill_evt && !bus_rdata[BIT_LCHG]) |=> (!bus_rdata[BIT_LOCK] && !bus_rdata[BIT_LCHG]));

  p_rise_flags_r5: assert property (@(posedge clk) disable iff (!por_n || sys_rst)
    $rose(bus_rdata[BIT_LOCK]) |-> bus_rdata[BIT_LCHG]);

  p_osc_drop_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!osc_en || stop_enter) |=> !osc_mon_en);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!por_n)
    !lock_irq_en |-> !irq);

  p_spare_zero_r11: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rdata[7] == 1'b0) && (bus_rdata[5] == 1'b0) && (bus_rdata[0] == 1'b0));
endmodule

bind clkgen_status_reg cgs_status_checker u_chk (
  .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .bus_wr_evt(bus_wr_evt),
  .bus_wdata(bus_wdata), .ill_acc(ill_acc), .kill_evt(kill_evt), .osc_en(osc_en),
  .stop_enter(stop_enter), .lock_irq_en(lock_irq_en), .bus_rdata(bus_rdata),
  .irq(irq), .osc_mon_en(osc_mon_en)
);

// File: tb/clkgen_status_reg_bench.sv
`timescale 1ns/1ps
module clkgen_status_reg_bench;
  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst = 1'b0, ill_acc = 1'b0;
  logic fll_lock_raw = 1'b0, osc_ready_raw = 1'b0, osc_en = 1'b0, stop_enter = 1'b0;
  logic [3:0] cfg_wr = 4'b0;
  logic lock_irq_en = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq, osc_mon_en;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkgen_status_reg u_clkgen_status_reg (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .ill_acc(ill_acc),
    .fll_lock_raw(fll_lock_raw), .osc_ready_raw(osc_ready_raw), .osc_en(osc_en),
    .stop_enter(stop_enter), .cfg_wr(cfg_wr), .lock_irq_en(lock_irq_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .osc_mon_en(osc_mon_en)
  );

  // Reference model, written from the requirements.
  logic m_l1, m_l2, m_o1, m_o2, m_lock, m_chg, m_up, m_por, m_ill;
  always @(posedge clk or negedge por_n) begin : model
    logic [7:0] clr;
    logic kill;
    if (!por_n) begin
      {m_l1, m_l2, m_o1, m_o2, m_lock, m_chg, m_up, m_ill} <= '0;
      m_por <= 1'b1;
    end else begin
      clr  = (bus_sel && bus_wr) ? bus_wdata : 8'h00;
      kill = stop_enter || (cfg_wr != 4'b0);
      m_por <= m_por && !clr[6];
      m_ill <= ill_acc || (m_ill && !clr[2]);
      if (sys_rst) begin
        {m_l1, m_l2, m_o1, m_o2, m_lock, m_chg, m_up} <= '0;
      end else begin
        m_l1 <= fll_lock_raw;  m_l2 <= m_l1;
        m_o1 <= osc_ready_raw; m_o2 <= m_o1;
        m_lock <= kill ? 1'b0 : m_l2;
        m_chg  <= (!kill && (m_l2 != m_lock)) || (m_chg && !clr[4]);
        if (!osc_en || stop_enter) m_up <= 1'b0;
        else if (m_o2)             m_up <= 1'b1;
      end
    end
  end

  function automatic logic [7:0] model_image(logic por, logic chg, logic lock,
                                             logic ill, logic up);
    return (8'(por) << 6) | (8'(chg) << 4) | (8'(lock) << 3) | (8'(ill) << 2) | (8'(up) << 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic bus_write(input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic sys_pulse();
    sys_rst = 1'b1; tick(); sys_rst = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 image in reset", bus_rdata, 8'h40);
    por_n = 1'b1;
    chk("R1 image after reset", bus_rdata, 8'h40);
    chk("R1 irq", irq, 0);
    chk("R1 osc_mon_en", osc_mon_en, 0);

    // R2 power-on flag
    bus_write(8'h00);
    chk("R2 write0 keeps", bus_rdata[6], 1);
    sys_pulse();
    chk("R2 sys_rst keeps", bus_rdata[6], 1);
    bus_write(8'h40);
    chk("R2 write1 clears", bus_rdata, 8'h00);

    // R3 illegal-address flag and R10 priority
    ill_acc = 1'b1; tick(); ill_acc = 1'b0;
    chk("R3 set", bus_rdata, 8'h04);
    sys_pulse();
    chk("R3 sys_rst keeps", bus_rdata[2], 1);
    ill_acc = 1'b1; bus_write(8'h04); ill_acc = 1'b0;
    chk("R10 set beats clear", bus_rdata[2], 1);
    bus_write(8'h04);
    chk("R3 write1 clears", bus_rdata[2], 0);
    ill_acc = 1'b1; tick(); ill_acc = 1'b0;
    por_n = 1'b0; tick(); por_n = 1'b1;
    chk("R3 por clears, R1 image", bus_rdata, 8'h40);
    bus_write(8'h40);

    // R4 lock status and R5 change flag, R9 irq
    lock_irq_en = 1'b0;
    fll_lock_raw = 1'b1;
    ticks(2);
    chk("R4 not yet after two edges", bus_rdata[3], 0);
    tick();
    chk("R4 follows on third edge", bus_rdata[3], 1);
    chk("R5 set on rise", bus_rdata[4], 1);
    chk("R9 irq gated off", irq, 0);
    lock_irq_en = 1'b1; #1;
    chk("R9 irq on", irq, 1);
    bus_write(8'h08);
    chk("R4 write ignored", bus_rdata[3], 1);
    chk("R5 not cleared by write0", bus_rdata[4], 1);
    bus_write(8'h10);
    chk("R5 write1 clears", bus_rdata[4], 0);
    chk("R9 irq drops", irq, 0);

    // R6 kills
    cfg_wr = 4'b0100; tick(); cfg_wr = 4'b0;
    chk("R6 cfg write drops lock", bus_rdata[3], 0);
    chk("R6 no change flag", bus_rdata[4], 0);
    tick();
    chk("R4 relock after kill", bus_rdata[3], 1);
    chk("R5 set on relock", bus_rdata[4], 1);
    bus_write(8'h10);
    stop_enter = 1'b1; tick(); stop_enter = 1'b0;
    chk("R6 stop drops lock", bus_rdata[4:3], 2'b00);
    tick();
    bus_write(8'h10);
    fll_lock_raw = 1'b0;
    ticks(3);
    chk("R5 set on fall", bus_rdata[4:3], 2'b10);
    bus_write(8'h10);

    // R7 oscillator-up, R8 monitor enable
    osc_en = 1'b1; osc_ready_raw = 1'b1;
    ticks(2);
    chk("R7 not yet", bus_rdata[1], 0);
    tick();
    chk("R7 up on third edge", bus_rdata[1], 1);
    chk("R8 monitor on", osc_mon_en, 1);
    osc_ready_raw = 1'b0;
    ticks(4);
    chk("R7 holds", bus_rdata[1], 1);
    bus_write(8'h02);
    chk("R7 write ignored", bus_rdata[1], 1);
    stop_enter = 1'b1; tick(); stop_enter = 1'b0;
    chk("R7 stop clears", bus_rdata[1], 0);
    chk("R8 monitor off", osc_mon_en, 0);
    osc_ready_raw = 1'b1;
    ticks(3);
    chk("R7 up again", bus_rdata[1], 1);
    osc_en = 1'b0; tick();
    chk("R7 disable clears", bus_rdata[1], 0);

    // R12 system reset scope
    osc_en = 1'b1; fll_lock_raw = 1'b1;
    ill_acc = 1'b1; tick(); ill_acc = 1'b0;
    ticks(3);
    chk("R12 before", bus_rdata, 8'h1E);
    sys_pulse();
    chk("R12 after sys_rst", bus_rdata, 8'h04);

    // Random phase against the model
    for (int i = 0; i < 3000; i++) begin
      ill_acc      = ($urandom % 8) == 0;
      if (($urandom % 16) == 0) fll_lock_raw  = ~fll_lock_raw;
      if (($urandom % 8)  == 0) osc_ready_raw = ~osc_ready_raw;
      osc_en       = ($urandom % 32) != 0;
      stop_enter   = ($urandom % 32) == 0;
      cfg_wr       = 4'(($urandom % 8) == 0 ? (1 << ($urandom % 4)) : 0);
      sys_rst      = ($urandom % 64) == 0;
      lock_irq_en  = 1'($urandom);
      bus_sel      = ($urandom % 4) == 0;
      bus_wr       = 1'($urandom);
      bus_wdata    = 8'($urandom);
      tick();
      chk("R12 R5 R6 random image", bus_rdata,
          model_image(m_por, m_chg, m_lock, m_ill, m_up));
      chk("R9 random irq", irq, m_chg & lock_irq_en);
      chk("R8 random monitor", osc_mon_en, bus_rdata[1]);
      chk("R11 spare bits", bus_rdata & 8'hA1, 8'h00);
    end
    done = 1'b1;
    summary();
  end
endmodule